// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a small 32-bit processor that finishes every instruction in one clock cycle. In a single cycle it fetches from an instruction store that is read without a clock, decodes the instruction and reads two operands from a 32-entry register file. It then computes a result or an address in one shared arithmetic unit and, at the next rising edge, commits the register write, the data-store write and the new program counter.

Load and store addresses come from the same adder that serves register arithmetic. A base register plus a sign-extended 16-bit offset gives a byte address, and bits [A+1:2] of that address select the word. Both memories are internal word arrays that the surrounding environment fills with a program and with data. The only outputs are debug observers: the current program counter and the register write-back happening in the current cycle.

The instruction set is eleven operations: six register-register operations, an add-immediate, word load, word store, branch-if-equal and an absolute jump. Any other encoding does nothing and moves on to the next instruction.

Top module: `mlc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 and all 31 writable registers are cleared. While `rst_n` is low, `dbg_wb_en` stays low. The first instruction after release is fetched from byte address 0.
- R2: Every instruction other than a taken branch or a jump sets the next PC to PC+4. This includes loads, stores and undefined encodings. The PC is always word aligned.
- R3: Opcode 0x08 (bits [31:26]) writes rs (bits [25:21]) plus the sign-extended 16-bit immediate (bits [15:0]) to rt (bits [20:16]). Every immediate is sign-extended before use, so 0xFFFD counts as -3 and 0x7FFF as +32767.
- R4: Opcode 0 selects a register operation by funct (bits [5:0]): 0x20 add, 0x22 subtract (rs-rt), 0x24 and, 0x25 or, 0x2A signed set-less-than, 0x18 multiply (low 32 bits of the signed product). The result goes to rd (bits [15:11]).
- R5: Opcode 0x23 loads the data word at rs+sext(imm) into rt. The loaded value can be used by the very next instruction.
- R6: Opcode 0x2B stores rt to the data word at rs+sext(imm) at the rising edge and writes no register.
- R7: Opcode 0x04 branches to PC+4+(sext(imm)<<2) when rs equals rt, and goes to PC+4 otherwise. Both forward and backward offsets work.
- R8: Opcode 0x02 jumps to {PC+4[31:28], bits [25:0], 2'b00}.
- R9: Register 0 always reads as zero, and writes to it have no effect and are not reported.
- R10: An opcode, or an opcode-0 funct, outside R3-R8 writes neither a register nor memory.
- R11: `dbg_wb_en` is high exactly in the cycles that commit a register write to a nonzero register. In those cycles `dbg_wb_idx` and `dbg_wb_data` give the destination and the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_pc | output | 32 | Byte address of the instruction executing this cycle |
| dbg_wb_en | output | 1 | A register write to a nonzero register commits at the next edge |
| dbg_wb_idx | output | 5 | Destination register of that write |
| dbg_wb_data | output | 32 | Value being written |

## Verification
A single program covers every operation with operands that give different answers under different operations. With 5 and -3, or, add, subtract, multiply and set-less-than each produce a distinct result, so an error in operation selection or in signed handling shows up at once. Stores with positive and negative offsets are followed by loads into the next instruction, which separates wrong address arithmetic, a lost store and a stale load from one another. A branch that is not taken, a forward taken branch, a counted backward loop and jumps fix each next-PC source through the exact PC trace. A write to register 0 and an undefined opcode must leave both the trace and the write-back stream unchanged.

// File: rtl/mlc_pkg.sv
// Shared encodings and control types for the single-cycle core.
// Assumes the standard 6-bit opcode at [31:26] and funct at [5:0].
package mlc_pkg;
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;
    localparam logic [5:0] FN_MUL = 6'h18;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_MUL
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;      // instruction writes a register
        logic    dst_is_rd;   // destination is rd, not rt
        logic    use_imm;     // ALU operand B is the sign-extended immediate
        logic    mem_we;      // store
        logic    mem_to_reg;  // load
        logic    is_branch;   // branch-if-equal
        logic    is_jump;     // absolute jump
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/mlc_decode.sv
// Main decoder: turns opcode and funct into control signals.
// Assumes any encoding not listed decodes to a no-operation.
module mlc_decode
    import mlc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Purpose: one case tree per opcode; default is a no-operation.
    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, use_imm: 1'b0, mem_we: 1'b0,
                 mem_to_reg: 1'b0, is_branch: 1'b0, is_jump: 1'b0, alu_op: ALU_ADD};
        case (opcode)
            OP_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    FN_MUL:  ctrl.alu_op = ALU_MUL;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OP_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_LW: begin
                ctrl.reg_we     = 1'b1;
                ctrl.use_imm    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            OP_JUMP: ctrl.is_jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mlc_alu.sv
// Arithmetic unit shared by register operations, address generation
// and the branch compare. Assumes two's-complement operands.
module mlc_alu
    import mlc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);
    logic [2*W-1:0] prod;

    // Purpose: signed product; only the low half is used.
    always_comb prod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});

    // Purpose: select the operation result.
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_MUL: y = prod[W-1:0];
            default: y = a + b;
        endcase
    end

    // Purpose: equality flag for the branch.
    always_comb zero = (y == '0);
endmodule

// File: rtl/mlc_regfile.sv
// Register file: two asynchronous read ports, one synchronous write port.
// Entry 0 is hardwired to zero; the others clear on synchronous reset.
module mlc_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [NREGS];

    // Purpose: entry 0 is a constant zero.
    always_comb regs[0] = '0;

    for (genvar g = 1; g < NREGS; g++) begin : g_reg
        // Purpose: one storage row, written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == AW'(g))
                regs[g] <= wdata;
        end
    end

    // Purpose: combinational reads.
    always_comb begin
        rdata_a = regs[raddr_a];
        rdata_b = regs[raddr_b];
    end
endmodule

// File: rtl/mlc_wordmem.sv
// Word-addressed memory: combinational read, write on the rising edge.
// Contents are not reset; the environment loads them.
module mlc_wordmem #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [WORDS];

    // Purpose: store one word.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    // Purpose: read follows the address with no enable.
    always_comb rdata = mem[addr];
endmodule

// File: rtl/mlc_core.sv
// Single-cycle core top: PC, sign extension, next-PC selection and the
// write-back path. Assumes both memories are loaded before reset release.
module mlc_core
    import mlc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int W   = 32,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [31:0]  dbg_pc,
    output logic         dbg_wb_en,
    output logic [4:0]   dbg_wb_idx,
    output logic [31:0]  dbg_wb_data
);
    logic [W-1:0] pc, pc_plus4, pc_next, instr;
    logic [W-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, load_val, wb_data;
    logic [4:0]   rs, rt, rd, wb_idx;
    logic         alu_zero, wb_en, store_en;
    ctrl_t        ctrl;

    mlc_wordmem #(.W(W), .WORDS(IMEM_WORDS)) u_imem (
        .clk(clk), .we(1'b0), .addr(pc[IAW+1:2]), .wdata('0), .rdata(instr)
    );

    // Purpose: split the instruction fields and sign-extend the immediate.
    always_comb begin
        rs      = instr[25:21];
        rt      = instr[20:16];
        rd      = instr[15:11];
        imm_ext = {{16{instr[15]}}, instr[15:0]};
    end

    mlc_decode u_dec (.opcode(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl));

    // Purpose: destination select and write gating (register 0 never written).
    always_comb begin
        wb_idx   = ctrl.dst_is_rd ? rd : rt;
        wb_en    = rst_n && ctrl.reg_we && (wb_idx != 5'd0);
        store_en = rst_n && ctrl.mem_we;
    end

    mlc_regfile #(.W(W), .NREGS(32)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(wb_en), .waddr(wb_idx), .wdata(wb_data),
        .raddr_a(rs), .raddr_b(rt), .rdata_a(rs_val), .rdata_b(rt_val)
    );

    // Purpose: ALU operand B is either rt or the immediate.
    always_comb alu_b = ctrl.use_imm ? imm_ext : rt_val;

    mlc_alu #(.W(W)) u_alu (
        .op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero)
    );

    mlc_wordmem #(.W(W), .WORDS(DMEM_WORDS)) u_dmem (
        .clk(clk), .we(store_en), .addr(alu_y[DAW+1:2]), .wdata(rt_val), .rdata(load_val)
    );

    // Purpose: pick the value written back.
    always_comb wb_data = ctrl.mem_to_reg ? load_val : alu_y;

    // Purpose: next-PC selection among sequential, branch and jump.
    always_comb begin
        pc_plus4 = pc + 32'd4;
        if (ctrl.is_jump)
            pc_next = {pc_plus4[31:28], instr[25:0], 2'b00};
        else if (ctrl.is_branch && alu_zero)
            pc_next = pc_plus4 + {imm_ext[29:0], 2'b00};
        else
            pc_next = pc_plus4;
    end

    // Purpose: program counter, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else
            pc <= pc_next;
    end

    // Purpose: debug observers.
    always_comb begin
        dbg_pc      = pc;
        dbg_wb_en   = wb_en;
        dbg_wb_idx  = wb_idx;
        dbg_wb_data = wb_data;
    end
endmodule

// File: rtl/mlc_core_checks.sv
// Property checker for mlc_core, attached through bind.
module mlc_core_checks (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr,
    input logic [31:0] dbg_pc,
    input logic        dbg_wb_en,
    input logic [4:0]  dbg_wb_idx
);
    a_r1_reset_pc: assert property (@(posedge clk) !rst_n |=> dbg_pc == 32'd0);

    a_r1_no_wb_in_reset: assert property (@(posedge clk) !rst_n |-> !dbg_wb_en);

    a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_pc[1:0] == 2'b00);

    a_r6_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        instr[31:26] == 6'h2B |-> !dbg_wb_en);

    a_r8_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        instr[31:26] == 6'h02 |=> dbg_pc[27:2] == $past(instr[25:0]));

    a_r9_zero_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_wb_en |-> dbg_wb_idx != 5'd0);

    a_r10_undefined_steps: assert property (@(posedge clk) disable iff (!rst_n)
        instr[31:26] == 6'h3F |=> dbg_pc == $past(dbg_pc) + 32'd4);

    a_r10_undefined_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        instr[31:26] == 6'h3F |-> !dbg_wb_en);
endmodule

bind mlc_core mlc_core_checks u_chk (
    .clk(clk), .rst_n(rst_n), .instr(instr), .dbg_pc(dbg_pc),
    .dbg_wb_en(dbg_wb_en), .dbg_wb_idx(dbg_wb_idx)
);

// File: tb/test_mlc_core.sv
// Scoreboard bench: the driver loads a program and queues expected PCs and
// write-backs; the monitor pops and compares them every cycle.
module test_mlc_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dbg_pc, dbg_wb_data;
    logic        dbg_wb_en;
    logic [4:0]  dbg_wb_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] pc_q [$];
    logic [36:0] wb_q [$];   // {idx, data}
    string       wb_tag [$];

    mlc_core i_mlc_core (
        .clk(clk), .rst_n(rst_n), .dbg_pc(dbg_pc), .dbg_wb_en(dbg_wb_en),
        .dbg_wb_idx(dbg_wb_idx), .dbg_wb_data(dbg_wb_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rop(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] iop(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] jop(int tgt);
        return {6'h02, 26'(tgt)};
    endfunction

    task automatic check(bit ok, string req, logic [36:0] act, logic [36:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_wb(int idx, logic [31:0] data, string req);
        wb_q.push_back({5'(idx), data});
        wb_tag.push_back(req);
    endtask

    // Driver: program, data image and expected streams.
    initial begin
        logic [31:0] prog [30];
        prog[0]  = iop(6'h08, 0, 1, 5);            // R3 addi r1=5
        prog[1]  = iop(6'h08, 0, 2, -3);           // R3 r2=-3
        prog[2]  = rop(1, 2, 3, 6'h20);            // R4 add
        prog[3]  = rop(1, 2, 4, 6'h22);            // R4 sub
        prog[4]  = rop(1, 2, 5, 6'h25);            // R4 or
        prog[5]  = rop(1, 2, 6, 6'h24);            // R4 and
        prog[6]  = rop(1, 2, 7, 6'h18);            // R4 mul
        prog[7]  = rop(2, 1, 8, 6'h2A);            // R4 slt
        prog[8]  = iop(6'h08, 0, 9, 16);           // r9=16
        prog[9]  = iop(6'h2B, 9, 7, 4);            // R6 sw r7 -> byte 20
        prog[10] = iop(6'h2B, 9, 4, -4);           // R6 sw r4 -> byte 12
        prog[11] = iop(6'h23, 9, 10, 4);           // R5 lw r10
        prog[12] = iop(6'h23, 9, 11, -4);          // R5 lw r11
        prog[13] = rop(10, 11, 12, 6'h20);         // R5 load used next
        prog[14] = iop(6'h08, 0, 0, 7);            // R9 write r0
        prog[15] = rop(0, 1, 13, 6'h20);           // R9 r0 reads 0
        prog[16] = iop(6'h04, 1, 2, 5);            // R7 not taken
        prog[17] = iop(6'h04, 3, 3, 2);            // R7 taken forward
        prog[18] = iop(6'h08, 0, 14, 1);
        prog[19] = iop(6'h08, 0, 14, 2);
        prog[20] = jop(23);                        // R8
        prog[21] = iop(6'h08, 0, 15, 1);
        prog[22] = iop(6'h08, 0, 15, 1);
        prog[23] = iop(6'h08, 0, 18, 3);
        prog[24] = iop(6'h08, 16, 16, 1);          // loop body
        prog[25] = iop(6'h04, 16, 18, 1);          // R7 exit when equal
        prog[26] = jop(24);                        // R8 backward
        prog[27] = {6'h3F, 26'h0ABCDEF};           // R10 undefined
        prog[28] = iop(6'h08, 0, 19, 16'h7FFF);    // R3 positive max
        prog[29] = jop(29);                        // hold
        for (int i = 0; i < 64; i++) begin
            i_mlc_core.u_imem.mem[i] = (i < 30) ? prog[i] : 32'h0;
            i_mlc_core.u_dmem.mem[i] = 32'hA5A5A5A5;
        end

        for (int w = 0; w <= 17; w++) pc_q.push_back(32'(w * 4));
        pc_q.push_back(80);  pc_q.push_back(92);
        for (int k = 0; k < 2; k++) begin
            pc_q.push_back(96); pc_q.push_back(100); pc_q.push_back(104);
        end
        pc_q.push_back(96);  pc_q.push_back(100); pc_q.push_back(108);
        pc_q.push_back(112); pc_q.push_back(116); pc_q.push_back(116);
        pc_q.push_back(116);

        expect_wb(1, 32'd5, "R3");
        expect_wb(2, 32'hFFFFFFFD, "R3");
        expect_wb(3, 32'd2, "R4");
        expect_wb(4, 32'd8, "R4");
        expect_wb(5, 32'hFFFFFFFD, "R4");
        expect_wb(6, 32'd5, "R4");
        expect_wb(7, 32'hFFFFFFF1, "R4");
        expect_wb(8, 32'd1, "R4");
        expect_wb(9, 32'd16, "R11");
        expect_wb(10, 32'hFFFFFFF1, "R6");
        expect_wb(11, 32'd8, "R6");
        expect_wb(12, 32'hFFFFFFF9, "R5");
        expect_wb(13, 32'd5, "R9");
        expect_wb(18, 32'd3, "R8");
        expect_wb(16, 32'd1, "R7");
        expect_wb(16, 32'd2, "R7");
        expect_wb(16, 32'd3, "R7");
        expect_wb(19, 32'h00007FFF, "R3");

        repeat (3) @(negedge clk);
        #1;
        check(dbg_pc == 32'd0, "R1", {5'd0, dbg_pc}, 37'd0);
        check(!dbg_wb_en, "R1", {36'd0, dbg_wb_en}, 37'd0);
        @(negedge clk);
        rst_n = 1'b1;
    end

    // Monitor: pop and compare once per cycle, away from the clock edge.
    initial begin
        @(posedge rst_n);
        while (pc_q.size() > 0) begin
            logic [31:0] ep;
            #1;
            ep = pc_q.pop_front();
            check(dbg_pc == ep, "R2/R7/R8 pc", {5'd0, dbg_pc}, {5'd0, ep});
            if (dbg_wb_en) begin
                if (wb_q.size() == 0) begin
                    check(1'b0, "R11 unexpected write", {dbg_wb_idx, dbg_wb_data}, 37'd0);
                end else begin
                    logic [36:0] ew;
                    string       tg;
                    ew = wb_q.pop_front();
                    tg = wb_tag.pop_front();
                    check({dbg_wb_idx, dbg_wb_data} == ew, tg,
                          {dbg_wb_idx, dbg_wb_data}, ew);
                end
            end
            @(negedge clk);
        end
        check(wb_q.size() == 0, "R11 missing writes", 37'(wb_q.size()), 37'd0);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                check(1'b0, "watchdog", 37'd0, 37'd1);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule